// File: doc/BRIEF.md
# Periodic Tick Timer with Interrupt Mask and Acknowledge

A register-controlled timer that counts down from a programmed divider and raises a periodic tick interrupt. Software programs the divider, then issues a load operation that copies the divider into the counter, then a separate run operation that starts the count. A frequency-select field picks how often the counter steps: every clock cycle, or once every 2, 4 or 8 cycles. When the counter steps while it holds zero, it reloads from the divider and flags a pending interrupt.

Interrupt handling uses a raw status bit, a mask bit, a masked status view and a write-one-to-acknowledge register. The interrupt output is high while any masked status bit is set and stays high until software acknowledges it. The live count can be read at any time, so software can measure how far the current period has run. The divider may be rewritten while the timer runs, and the new period begins at the next reload.

The register interface is a single-cycle write port and a combinational read port. Registers sit at these word addresses: 0 divider (read/write), 1 control (read/write), 2 live count (read-only), 3 raw status (read-only), 4 mask (read/write), 5 masked status (read-only), 6 acknowledge (write-only, reads 0).

Top module: `tick_timer`

## Requirements
- R1: After reset the count, divider, control, raw status and mask read 0, the timer is stopped and `irq` is low.
- R2: Control bits [1:0] hold the operation: 1 loads the counter from the divider and leaves the timer stopped; 0 and 3 stop the timer and freeze the count. The control register reads back the last written operation and frequency select.
- R3: Operation 2 starts the timer. On each count-clock step the count falls by one, and the count reads back at address 2.
- R4: Control bits [3:2] hold the frequency select k. The counter steps once every 2^k clock cycles, so k = 0 steps at the full clock rate. The step phase restarts at every control write, and no step happens in the cycle of a control write.
- R5: A step taken while the count is 0 reloads the counter from the divider and sets raw status bit 0 in the same cycle. This gives a period of divider + 1 steps, and a read just after a wrap returns a larger value than the read just before it.
- R6: A divider written while the timer runs does not change the current count. It takes effect at the next reload.
- R7: A divider value of 0 loads and reloads as 2^16 - 1, the longest period, so the timer never wraps on every step.
- R8: Mask bit 0 at address 4 gates the interrupt. Address 5 reads raw AND mask, and `irq` is high exactly while that value is non-zero, holding until acknowledged.
- R9: Writing 1 to bit 0 at address 6 clears raw status; writing 0 has no effect. If an acknowledge and a wrap fall in the same cycle, the raw bit stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Read data for `rd_addr`, combinational |
| irq | output | 1 | Tick interrupt, high while a masked status bit is pending |

## Verification
The assertions assume that writes only arrive as single-cycle strobes with a defined address, that the divider fits in the 16-bit count, and that reset is held for at least one clock edge before any write. The bench drives every write for exactly one cycle between falling edges, holds reset low for several edges before the first write, and keeps every divider inside 16 bits. It reaches the acknowledge-versus-wrap collision by counting steps from a known load, not by free-running timing.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_LOAD = 2'd1,
    OP_RUN  = 2'd2,
    OP_HALT = 2'd3
  } op_e;

  localparam int unsigned REG_DIV    = 0;
  localparam int unsigned REG_CTRL   = 1;
  localparam int unsigned REG_COUNT  = 2;
  localparam int unsigned REG_RAW    = 3;
  localparam int unsigned REG_MASK   = 4;
  localparam int unsigned REG_MASKED = 5;
  localparam int unsigned REG_ACK    = 6;

  localparam int unsigned OP_LSB   = 0;
  localparam int unsigned FSEL_LSB = 2;

  // Value the counter takes on load or wrap: zero stands for the longest period.
  function automatic logic [31:0] reload_of(input logic [31:0] div, input int unsigned width);
    logic [31:0] top;
    top = (32'h1 << width) - 32'h1;
    return (div == 32'h0) ? top : div;
  endfunction

  // Low-bit mask for a prescale of 2^sel cycles per step.
  function automatic logic [31:0] step_mask(input int unsigned sel);
    return (32'h1 << sel) - 32'h1;
  endfunction

endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler
  import tick_timer_pkg::*;
#(
  parameter int unsigned FSEL_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              run,
  input  logic [FSEL_W-1:0] fsel,
  output logic              tick
);
  localparam int unsigned PRE_W = (1 << FSEL_W) - 1;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] lim;

  assign lim  = PRE_W'(step_mask(int'(fsel)));
  assign tick = run && !restart && ((pre_q & lim) == lim);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else if (restart) begin
      pre_q <= '0;
    end else if (run) begin
      pre_q <= pre_q + 1'b1;
    end
  end
endmodule

// File: rtl/tick_counter.sv
module tick_counter
  import tick_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             tick,
  input  logic [CNT_W-1:0] div,
  output logic [CNT_W-1:0] count,
  output logic             underflow
);
  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] reload_val;

  assign reload_val = CNT_W'(reload_of(32'(div), CNT_W));
  assign underflow  = tick && (count_q == '0);
  assign count      = count_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (load) begin
      count_q <= reload_val;
    end else if (tick) begin
      count_q <= underflow ? reload_val : count_q - 1'b1;
    end
  end
endmodule

// File: rtl/tick_irq_ctrl.sv
module tick_irq_ctrl #(
  parameter int unsigned SRC_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_W-1:0] set,
  input  logic [SRC_W-1:0] ack,
  input  logic             mask_wr,
  input  logic [SRC_W-1:0] mask_d,
  output logic [SRC_W-1:0] raw,
  output logic [SRC_W-1:0] mask,
  output logic [SRC_W-1:0] masked,
  output logic             irq
);
  logic [SRC_W-1:0] raw_q;
  logic [SRC_W-1:0] mask_q;

  // A new event in the same cycle as an acknowledge wins.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raw_q <= '0;
    end else begin
      raw_q <= set | (raw_q & ~ack);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (mask_wr) begin
      mask_q <= mask_d;
    end
  end

  assign raw    = raw_q;
  assign mask   = mask_q;
  assign masked = raw_q & mask_q;
  assign irq    = |masked;
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned FSEL_W = 2,
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);
  localparam int unsigned SRC_W = 1;

  logic [CNT_W-1:0]  div_q;
  logic [1:0]        op_q;
  logic [FSEL_W-1:0] fsel_q;
  logic              running_q;

  logic              div_wr;
  logic              ctrl_wr;
  logic              mask_wr;
  logic              ack_wr;
  logic [1:0]        op_in;
  logic              load_evt;
  logic              tick_w;
  logic              underflow_w;
  logic [CNT_W-1:0]  count_w;
  logic [SRC_W-1:0]  ack_w;
  logic [SRC_W-1:0]  raw_w;
  logic [SRC_W-1:0]  mask_w;
  logic [SRC_W-1:0]  masked_w;
  logic              unused_bits;

  assign div_wr   = wr_en && (wr_addr == ADDR_W'(REG_DIV));
  assign ctrl_wr  = wr_en && (wr_addr == ADDR_W'(REG_CTRL));
  assign mask_wr  = wr_en && (wr_addr == ADDR_W'(REG_MASK));
  assign ack_wr   = wr_en && (wr_addr == ADDR_W'(REG_ACK));
  assign op_in    = wr_data[OP_LSB +: 2];
  assign load_evt = ctrl_wr && (op_in == OP_LOAD);
  assign ack_w    = ack_wr ? wr_data[SRC_W-1:0] : '0;

  assign unused_bits = ^wr_data[DATA_W-1:CNT_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q <= '0;
    end else if (div_wr) begin
      div_q <= wr_data[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q      <= OP_HOLD;
      fsel_q    <= '0;
      running_q <= 1'b0;
    end else if (ctrl_wr) begin
      op_q      <= op_in;
      fsel_q    <= wr_data[FSEL_LSB +: FSEL_W];
      running_q <= (op_in == OP_RUN);
    end
  end

  tick_prescaler #(
    .FSEL_W(FSEL_W)
  ) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .restart(ctrl_wr),
    .run    (running_q),
    .fsel   (fsel_q),
    .tick   (tick_w)
  );

  tick_counter #(
    .CNT_W(CNT_W)
  ) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load_evt),
    .tick     (tick_w),
    .div      (div_q),
    .count    (count_w),
    .underflow(underflow_w)
  );

  tick_irq_ctrl #(
    .SRC_W(SRC_W)
  ) u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .set    (underflow_w),
    .ack    (ack_w),
    .mask_wr(mask_wr),
    .mask_d (wr_data[SRC_W-1:0]),
    .raw    (raw_w),
    .mask   (mask_w),
    .masked (masked_w),
    .irq    (irq)
  );

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      ADDR_W'(REG_DIV):    rd_data[CNT_W-1:0] = div_q;
      ADDR_W'(REG_CTRL): begin
        rd_data[OP_LSB +: 2]        = op_q;
        rd_data[FSEL_LSB +: FSEL_W] = fsel_q;
      end
      ADDR_W'(REG_COUNT):  rd_data[CNT_W-1:0] = count_w;
      ADDR_W'(REG_RAW):    rd_data[SRC_W-1:0] = raw_w;
      ADDR_W'(REG_MASK):   rd_data[SRC_W-1:0] = mask_w;
      ADDR_W'(REG_MASKED): rd_data[SRC_W-1:0] = masked_w;
      default:             rd_data = '0;
    endcase
  end
endmodule

// File: rtl/tick_timer_checker.sv
module tick_timer_checker #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             running,
  input logic             load,
  input logic             tick,
  input logic             underflow,
  input logic [CNT_W-1:0] div,
  input logic [CNT_W-1:0] count,
  input logic             raw,
  input logic             mask,
  input logic             ack,
  input logic             irq
);
  p_load_copies_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (count == $past(div)) || ($past(div) == '0 && count == '1));

  p_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(count));

  p_step_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && count != '0) |=> count == $past(count) - 1'b1);

  p_no_step_stopped_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !tick);

  p_wrap_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> (count == $past(div)) || ($past(div) == '0 && count == '1));

  p_wrap_sets_raw_r5: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> raw);

  p_raw_has_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(raw) |-> $past(underflow));

  p_irq_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (raw && mask));

  p_irq_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !ack && $stable(mask)) |=> irq);

  p_ack_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !underflow) |=> !raw);

  p_wrap_beats_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && underflow) |=> raw);
endmodule

bind tick_timer tick_timer_checker #(
  .CNT_W(CNT_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .running  (running_q),
  .load     (load_evt),
  .tick     (tick_w),
  .underflow(underflow_w),
  .div      (div_q),
  .count    (count_w),
  .raw      (raw_w[0]),
  .mask     (mask_w[0]),
  .ack      (ack_w[0]),
  .irq      (irq)
);

// File: tb/tick_timer_test.sv
`timescale 1ns/100ps
module tick_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        irq;

  int checks = 0;
  int errors = 0;
  logic [31:0] v;
  logic [31:0] before_wrap;

  localparam logic [2:0] A_DIV = 3'd0, A_CTRL = 3'd1, A_CNT = 3'd2, A_RAW = 3'd3,
                         A_MASK = 3'd4, A_MASKED = 3'd5, A_ACK = 3'd6;
  localparam logic [31:0] C_STOP = 32'd0, C_LOAD = 32'd1, C_RUN = 32'd2, C_HALT = 32'd3;

  // {divider, freq select, cycles to wait after run, expected count, expected raw}
  localparam int NV = 7;
  localparam logic [63:0] VECS [0:NV-1] = '{
    {16'd5,  8'd0, 16'd3,  16'd2, 8'd0},
    {16'd5,  8'd0, 16'd6,  16'd5, 8'd1},
    {16'd3,  8'd1, 16'd7,  16'd0, 8'd0},
    {16'd3,  8'd1, 16'd8,  16'd3, 8'd1},
    {16'd10, 8'd2, 16'd20, 16'd5, 8'd0},
    {16'd2,  8'd3, 16'd24, 16'd2, 8'd1},
    {16'd7,  8'd0, 16'd20, 16'd3, 8'd1}
  };

  always #2.5 clk = ~clk;

  tick_timer uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    rd_addr = a;
    #0.1;
    d = rd_data;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait_cyc(4);
    rst_n = 1'b1;
    // R1: reset state
    rd(A_CNT, v);  check("R1 count", v, 0);
    rd(A_DIV, v);  check("R1 divider", v, 0);
    rd(A_CTRL, v); check("R1 control", v, 0);
    rd(A_RAW, v);  check("R1 raw", v, 0);
    rd(A_MASK, v); check("R1 mask", v, 0);
    check("R1 irq", {31'd0, irq}, 0);

    // R3 R4 R5: table of periods and prescales
    for (int i = 0; i < NV; i++) begin
      logic [31:0] fs;
      fs = {24'd0, VECS[i][47:40]} << 2;
      wr(A_CTRL, C_STOP);
      wr(A_ACK, 32'd1);
      wr(A_DIV, {16'd0, VECS[i][63:48]});
      wr(A_CTRL, C_LOAD | fs);
      wr(A_CTRL, C_RUN | fs);
      wait_cyc(int'(VECS[i][39:24]));
      rd(A_CNT, v); check($sformatf("R3 R4 vector %0d count", i), v, {16'd0, VECS[i][23:8]});
      rd(A_RAW, v); check($sformatf("R5 vector %0d raw", i), v, {24'd0, VECS[i][7:0]});
    end

    // R2: load without run, then stop freezes
    wr(A_CTRL, C_STOP);
    wr(A_ACK, 32'd1);
    wr(A_DIV, 32'd9);
    wr(A_CTRL, C_LOAD);
    wait_cyc(5);
    rd(A_CNT, v); check("R2 load holds", v, 9);
    wr(A_CTRL, C_RUN);
    wait_cyc(2);
    rd(A_CNT, v); check("R3 run steps", v, 7);
    wr(A_CTRL, C_HALT);
    wait_cyc(3);
    rd(A_CNT, v); check("R2 op3 freezes", v, 7);
    rd(A_CTRL, v); check("R2 control readback", v, 3);

    // R7: divider 0 means longest period
    wr(A_DIV, 32'd0);
    wr(A_CTRL, C_LOAD);
    rd(A_CNT, v); check("R7 zero divider load", v, 65535);
    wr(A_CTRL, C_RUN);
    wait_cyc(3);
    rd(A_CNT, v); check("R7 zero divider run", v, 65532);
    rd(A_RAW, v); check("R7 no early wrap", v, 0);

    // R6: divider rewrite takes effect at next reload
    wr(A_CTRL, C_STOP);
    wr(A_ACK, 32'd1);
    wr(A_DIV, 32'd4);
    wr(A_CTRL, C_LOAD);
    wr(A_CTRL, C_RUN);
    wait_cyc(2);
    rd(A_CNT, v); check("R6 before rewrite", v, 2);
    wr(A_DIV, 32'd8);
    rd(A_CNT, v); check("R6 current period kept", v, 1);
    wait_cyc(1);
    rd(A_CNT, before_wrap); check("R6 reaches zero", before_wrap, 0);
    wait_cyc(1);
    rd(A_CNT, v); check("R6 new reload", v, 8);
    check("R5 read after wrap larger", {31'd0, v > before_wrap}, 1);
    rd(A_RAW, v); check("R5 raw on wrap", v, 1);

    // R8: mask gating, irq held until acknowledged
    wr(A_CTRL, C_STOP);
    check("R8 irq masked off", {31'd0, irq}, 0);
    rd(A_MASKED, v); check("R8 masked reads 0", v, 0);
    wr(A_MASK, 32'd1);
    check("R8 irq unmasked", {31'd0, irq}, 1);
    rd(A_MASKED, v); check("R8 masked reads 1", v, 1);
    wait_cyc(4);
    check("R8 irq held", {31'd0, irq}, 1);
    wr(A_ACK, 32'd0);
    rd(A_RAW, v); check("R9 ack of 0 ignored", v, 1);
    check("R9 irq after ack of 0", {31'd0, irq}, 1);
    wr(A_ACK, 32'd1);
    check("R9 ack drops irq", {31'd0, irq}, 0);

    // R9: acknowledge colliding with a wrap
    wr(A_DIV, 32'd1);
    wr(A_CTRL, C_LOAD);
    wr(A_CTRL, C_RUN);
    wait_cyc(2);
    rd(A_RAW, v); check("R5 first wrap", v, 1);
    wait_cyc(1);
    wr(A_ACK, 32'd1);
    rd(A_RAW, v); check("R9 wrap wins over ack", v, 1);
    check("R9 irq stays on collision", {31'd0, irq}, 1);
    wr(A_ACK, 32'd1);
    rd(A_RAW, v); check("R9 ack clears", v, 0);
    check("R9 irq cleared", {31'd0, irq}, 0);
    rd(A_CTRL, v); check("R2 run readback", v, 2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule